// File: doc/BRIEF.md
# Single-Wire Bus Master with Microsecond Time Base

This block is a register-driven master for a single-wire, open-drain serial bus. Software sets one command bit in a byte-wide control register. The block then runs a complete timed bus sequence and clears that bit when the sequence is over. There are three sequences:

- a bus reset followed by a presence listen window;
- a write-zero slot;
- a combined write-one / read slot.

The result of a presence listen or of a read is held in status bits of the same control register. Those bits are meaningful only once the command bit has cleared.

All bus timing is counted in microseconds. A programmable prescaler divides the system clock by N, and software loads N-1 into a divider register. The block never drives the line high. It only raises a drive-low enable for an external open-drain pad. The line level comes back through a two-flop synchronizer. A third register holds the whole block idle while its bit 0 is set.

Top module: `onewire_master`

## Requirements
- R1: After reset, the control register (offset 0) reads 0x00, the divider (offset 2) reads 0x00, the hold register (offset 4) reads 0x00, and `lineDriveLow` is 0.
- R2: Writing bit 7 of the control register while idle starts a reset sequence. Bit 7 reads 1 for exactly (RST_LOW_US+RST_WAIT_US)*N clock cycles and then clears by itself.
- R3: During a reset sequence, `lineDriveLow` is 1 for the first RST_LOW_US microseconds and 0 for the rest of the sequence. The line is never driven while no command bit is set.
- R4: Bit 6 of the control register is the presence flag. It is cleared when a reset sequence starts. It is loaded with 1 if the synchronized line is low at RST_LOW_US+PRES_US microseconds into the sequence, and with 0 otherwise. It does not change at any other time.
- R5: Writing bit 5 while idle starts a write-zero slot. The slot drives the line low for W0_LOW_US microseconds, and bit 5 clears after SLOT_US*N cycles.
- R6: Writing bit 4 while idle starts a write-one/read slot. The slot drives the line low for W1_LOW_US microseconds. Bit 3 is cleared at the start of the slot and loaded with the synchronized line level at RD_SAMPLE_US microseconds. Bit 4 clears after SLOT_US*N cycles. Bit 3 changes at no other time.
- R7: The divider register at offset 2 holds N-1. One microsecond equals N clock cycles, and every sequence length scales with N.
- R8: Writing 1 to bit 0 at offset 4 aborts any sequence at once and clears the command, presence and read bits. While bit 0 stays set, commands are ignored and the line is not driven. Writing 0 releases the block. The divider value is kept through the hold.
- R9: If several command bits are written together, only one is accepted, in the order reset, then write-zero, then write-one/read. Only the accepted bit reads back as set.
- R10: A control write that arrives while a sequence is running is ignored. The running command bit, its timing and its end cycle are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 3 | Register byte offset for both read and write |
| regWrEn | input | 1 | Write strobe, sampled on the rising clock edge |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Combinational read data of the register at regAddr |
| lineIn | input | 1 | Bus line level from the pad |
| lineDriveLow | output | 1 | Pad enable that pulls the bus line low |

## Verification
The bench builds the block with shortened timing parameters:

| Parameter | Value |
|---|---|
| RST_LOW_US | 20 |
| RST_WAIT_US | 24 |
| PRES_US | 6 |
| W0_LOW_US | 10 |
| W1_LOW_US | 2 |
| RD_SAMPLE_US | 5 |
| SLOT_US | 12 |

With these values a full reset sequence is short enough to repeat many times. The bench runs it with the divider at N=1 and N=3, so the prescaler wrap and the microsecond-boundary compares are both exercised.

The read sample point is three cycles after the line is released at N=1. That is the smallest gap the two-flop synchronizer allows, so any added latency on the sampling path shows up as a wrong read bit.

// File: rtl/onewire_pkg.sv
package onewire_pkg;

  // Register byte offsets. Software depends on these.
  localparam logic [2:0] ADDR_CTRL = 3'd0;
  localparam logic [2:0] ADDR_DIV  = 3'd2;
  localparam logic [2:0] ADDR_HOLD = 3'd4;

  // Control register bit positions
  localparam int BIT_RST  = 7;
  localparam int BIT_PRES = 6;
  localparam int BIT_W0   = 5;
  localparam int BIT_W1   = 4;
  localparam int BIT_RD   = 3;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_RESET = 2'd1,
    OP_W0    = 2'd2,
    OP_W1    = 2'd3
  } op_e;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic start;
    op_e  kind;
    logic capPres;
    logic capRead;
    logic finish;
  } strobe_t;

endpackage

// File: rtl/onewire_ctrl.sv
module onewire_ctrl
  import onewire_pkg::*;
#(
  parameter int RST_LOW_US   = 511,
  parameter int RST_WAIT_US  = 512,
  parameter int PRES_US      = 70,
  parameter int W0_LOW_US    = 60,
  parameter int W1_LOW_US    = 5,
  parameter int RD_SAMPLE_US = 15,
  parameter int SLOT_US      = 65,
  parameter int US_W         = 10
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [2:0]      cmdReq,
  input  logic            holdNow,
  input  logic            tick,
  input  logic [US_W-1:0] usCnt,
  output strobe_t         stb,
  output logic            lineDriveLow
);

  localparam int RST_TOTAL = RST_LOW_US + RST_WAIT_US;

  op_e             state;
  logic [US_W-1:0] endAt;
  logic [US_W-1:0] lowFor;
  logic [US_W-1:0] sampAt;
  logic            lastUs;
  logic            sampUs;

  // Per-sequence timing limits, in microseconds
  always_comb begin
    endAt  = '0;
    lowFor = '0;
    sampAt = '0;
    case (state)
      OP_RESET: begin
        endAt  = US_W'(RST_TOTAL);
        lowFor = US_W'(RST_LOW_US);
        sampAt = US_W'(RST_LOW_US + PRES_US);
      end
      OP_W0: begin
        endAt  = US_W'(SLOT_US);
        lowFor = US_W'(W0_LOW_US);
      end
      OP_W1: begin
        endAt  = US_W'(SLOT_US);
        lowFor = US_W'(W1_LOW_US);
        sampAt = US_W'(RD_SAMPLE_US);
      end
      default: ;
    endcase
  end

  assign lastUs = tick && (usCnt == endAt - US_W'(1));
  assign sampUs = tick && (usCnt == sampAt - US_W'(1));

  always_comb begin
    stb = '0;
    if (state == OP_NONE) begin
      if (cmdReq[2]) begin
        stb.start = 1'b1;
        stb.kind  = OP_RESET;
      end else if (cmdReq[1]) begin
        stb.start = 1'b1;
        stb.kind  = OP_W0;
      end else if (cmdReq[0]) begin
        stb.start = 1'b1;
        stb.kind  = OP_W1;
      end
    end else begin
      stb.finish  = lastUs;
      stb.capPres = (state == OP_RESET) && sampUs;
      stb.capRead = (state == OP_W1) && sampUs;
    end
  end

  assign lineDriveLow = (state != OP_NONE) && (usCnt < lowFor);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= OP_NONE;
    else if (holdNow) state <= OP_NONE;
    else if (stb.start) state <= stb.kind;
    else if (stb.finish) state <= OP_NONE;
  end

endmodule

// File: rtl/onewire_dp.sv
module onewire_dp
  import onewire_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int US_W  = 10
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [2:0]      regAddr,
  input  logic            regWrEn,
  input  logic [7:0]      regWrData,
  output logic [7:0]      regRdData,
  input  logic            lineIn,
  input  strobe_t         stb,
  output logic            tick,
  output logic [US_W-1:0] usCnt,
  output logic [2:0]      cmdReq,
  output logic            holdNow,
  output logic [2:0]      cmdBits,
  output logic            holdOn,
  output logic            presBit,
  output logic            rdBit
);

  logic             wrCtrl;
  logic             wrDiv;
  logic             wrHold;
  logic [DIV_W-1:0] divReg;
  logic [DIV_W-1:0] preCnt;
  logic [1:0]       lineSync;
  logic             busy;

  assign wrCtrl  = regWrEn && (regAddr == ADDR_CTRL);
  assign wrDiv   = regWrEn && (regAddr == ADDR_DIV);
  assign wrHold  = regWrEn && (regAddr == ADDR_HOLD);
  assign holdNow = holdOn || (wrHold && regWrData[0]);
  assign busy    = |cmdBits;
  assign cmdReq  = (wrCtrl && !holdNow)
                   ? {regWrData[BIT_RST], regWrData[BIT_W0], regWrData[BIT_W1]}
                   : 3'b000;
  assign tick    = busy && (preCnt == divReg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdOn <= 1'b0;
      divReg <= '0;
    end else begin
      if (wrHold) holdOn <= regWrData[0];
      if (wrDiv) divReg <= regWrData[DIV_W-1:0];
    end
  end

  // Prescaler and microsecond counter, both restarted at each sequence
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      usCnt  <= '0;
    end else if (holdNow || stb.start) begin
      preCnt <= '0;
      usCnt  <= '0;
    end else if (busy) begin
      preCnt <= tick ? '0 : preCnt + DIV_W'(1);
      if (tick) usCnt <= usCnt + US_W'(1);
    end
  end

  // Line synchronizer, idle level is high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lineSync <= 2'b11;
    else lineSync <= {lineSync[0], lineIn};
  end

  // Command and status bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdBits <= '0;
      presBit <= 1'b0;
      rdBit   <= 1'b0;
    end else if (holdNow) begin
      cmdBits <= '0;
      presBit <= 1'b0;
      rdBit   <= 1'b0;
    end else if (stb.start) begin
      cmdBits <= {stb.kind == OP_RESET, stb.kind == OP_W0, stb.kind == OP_W1};
      if (stb.kind == OP_RESET) presBit <= 1'b0;
      if (stb.kind == OP_W1) rdBit <= 1'b0;
    end else begin
      if (stb.finish) cmdBits <= '0;
      if (stb.capPres) presBit <= !lineSync[1];
      if (stb.capRead) rdBit <= lineSync[1];
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_CTRL: begin
        regRdData[BIT_RST]  = cmdBits[2];
        regRdData[BIT_PRES] = presBit;
        regRdData[BIT_W0]   = cmdBits[1];
        regRdData[BIT_W1]   = cmdBits[0];
        regRdData[BIT_RD]   = rdBit;
      end
      ADDR_DIV:  regRdData[DIV_W-1:0] = divReg;
      ADDR_HOLD: regRdData[0] = holdOn;
      default: ;
    endcase
  end

endmodule

// File: rtl/onewire_master.sv
module onewire_master
  import onewire_pkg::*;
#(
  parameter int DIV_W        = 8,
  parameter int RST_LOW_US   = 511,
  parameter int RST_WAIT_US  = 512,
  parameter int PRES_US      = 70,
  parameter int W0_LOW_US    = 60,
  parameter int W1_LOW_US    = 5,
  parameter int RD_SAMPLE_US = 15,
  parameter int SLOT_US      = 65
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] regAddr,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  input  logic       lineIn,
  output logic       lineDriveLow
);

  localparam int RST_TOTAL = RST_LOW_US + RST_WAIT_US;
  localparam int MAX_US    = (RST_TOTAL > SLOT_US) ? RST_TOTAL : SLOT_US;
  localparam int US_W      = $clog2(MAX_US + 1);

  strobe_t         stb;
  logic            tick;
  logic [US_W-1:0] usCnt;
  logic [2:0]      cmdReq;
  logic            holdNow;
  logic [2:0]      cmdBits;
  logic            holdOn;
  logic            presBit;
  logic            rdBit;

  onewire_ctrl #(
    .RST_LOW_US(RST_LOW_US), .RST_WAIT_US(RST_WAIT_US), .PRES_US(PRES_US),
    .W0_LOW_US(W0_LOW_US), .W1_LOW_US(W1_LOW_US), .RD_SAMPLE_US(RD_SAMPLE_US),
    .SLOT_US(SLOT_US), .US_W(US_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdReq(cmdReq), .holdNow(holdNow), .tick(tick),
    .usCnt(usCnt), .stb(stb), .lineDriveLow(lineDriveLow)
  );

  onewire_dp #(.DIV_W(DIV_W), .US_W(US_W)) u_dp (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .lineIn(lineIn), .stb(stb),
    .tick(tick), .usCnt(usCnt), .cmdReq(cmdReq), .holdNow(holdNow),
    .cmdBits(cmdBits), .holdOn(holdOn), .presBit(presBit), .rdBit(rdBit)
  );

endmodule

// File: rtl/onewire_checker.sv
module onewire_checker (
  input logic       clk,
  input logic       rstN,
  input logic       regWrEn,
  input logic [2:0] cmdBits,
  input logic       holdOn,
  input logic       presBit,
  input logic       rdBit,
  input logic       lineDriveLow
);

  AST_CMD_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(cmdBits)); // R9

  AST_DRIVE_IN_OP: assert property (@(posedge clk) disable iff (!rstN)
    lineDriveLow |-> (cmdBits != 3'b000)); // R3

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    holdOn |-> (cmdBits == 3'b000 && !lineDriveLow)); // R8

  AST_BUSY_KEEPS_CMD: assert property (@(posedge clk) disable iff (!rstN)
    (cmdBits != 3'b000) |=> (cmdBits == $past(cmdBits) || cmdBits == 3'b000)); // R10

  AST_PRES_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!cmdBits[2] && !regWrEn) |=> $stable(presBit)); // R4

  AST_RD_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!cmdBits[0] && !regWrEn) |=> $stable(rdBit)); // R6

endmodule

bind onewire_master onewire_checker u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .cmdBits(cmdBits), .holdOn(holdOn),
  .presBit(presBit), .rdBit(rdBit), .lineDriveLow(lineDriveLow)
);

// File: tb/onewire_master_test.sv
`timescale 1ns/1ps
module onewire_master_test;

  localparam int RL = 20, RW = 24, PR = 6, W0L = 10, W1L = 2, RS = 5, SL = 12;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] regAddr = 3'd0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = 8'd0;
  logic [7:0] regRdData;
  logic       lineIn;
  logic       lineDriveLow;
  logic       slaveLow = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  assign lineIn = ~(lineDriveLow | slaveLow);

  always #2.5 clk = ~clk;

  onewire_master #(
    .RST_LOW_US(RL), .RST_WAIT_US(RW), .PRES_US(PR), .W0_LOW_US(W0L),
    .W1_LOW_US(W1L), .RD_SAMPLE_US(RS), .SLOT_US(SL)
  ) uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .lineIn(lineIn),
    .lineDriveLow(lineDriveLow)
  );

  // Behavioural reference: 0 idle, 1 reset, 2 write-0, 3 write-1/read
  int mKind = 0, mK = 0, mN = 1, mDiv = 0;
  bit mBusy = 0, mHold = 0, mPres = 0, mRd = 0;

  function automatic int lowUs(int kind);
    return (kind == 1) ? RL : (kind == 2) ? W0L : W1L;
  endfunction
  function automatic int totalUs(int kind);
    return (kind == 1) ? RL + RW : SL;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mBusy = 0; mKind = 0; mK = 0; mDiv = 0; mHold = 0; mPres = 0; mRd = 0;
    end else begin
      bit holdNowM;
      bit wasBusy;
      holdNowM = mHold || (regWrEn && regAddr == 3'd4 && regWrData[0]);
      wasBusy = mBusy;
      if (mBusy) begin
        mK++;
        if (mKind == 1 && mK == (RL + PR) * mN) mPres = slaveLow;
        if (mKind == 3 && mK == RS * mN) mRd = !slaveLow;
        if (mK == totalUs(mKind) * mN) mBusy = 0;
      end
      if (regWrEn && regAddr == 3'd2) mDiv = regWrData;
      if (!wasBusy && !holdNowM && regWrEn && regAddr == 3'd0 &&
          (regWrData[7] || regWrData[5] || regWrData[4])) begin
        mKind = regWrData[7] ? 1 : regWrData[5] ? 2 : 3;
        mK = 0; mBusy = 1; mN = mDiv + 1;
        if (mKind == 1) mPres = 0;
        if (mKind == 3) mRd = 0;
      end
      if (holdNowM) begin mBusy = 0; mPres = 0; mRd = 0; end
      if (regWrEn && regAddr == 3'd4) mHold = regWrData[0];
    end
  end

  // Cycle-by-cycle comparison of the pad enable (R3 R5 R6 R7 R8)
  always @(negedge clk) begin
    if (rstN && !done) begin
      bit expDrive;
      expDrive = mBusy && ((mK / mN) < lowUs(mKind));
      checks++;
      if (lineDriveLow !== expDrive) begin
        errors++;
        $display("FAIL R3/R5/R6/R7/R8 lineDriveLow kind=%0d k=%0d actual=%b expected=%b",
                 mKind, mK, lineDriveLow, expDrive);
      end
    end
  end

  function automatic logic [7:0] expCtrl();
    return {mBusy && mKind == 1, mPres, mBusy && mKind == 2, mBusy && mKind == 3,
            mRd, 3'b000};
  endfunction

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regAddr = 3'd0;
  endtask

  task automatic chk(input logic [2:0] a, input logic [7:0] e, input string req);
    regAddr = a;
    #1;
    checks++;
    if (regRdData !== e) begin
      errors++;
      $display("FAIL %s reg@%0d actual=%h expected=%h", req, a, regRdData, e);
    end
    regAddr = 3'd0;
  endtask

  // Count cycles a command bit stays set; wr() returns one negedge after start
  task automatic measure(input logic [7:0] cmd, input int exp, input string req);
    int n;
    n = 0;
    wr(3'd0, cmd);
    #1;
    while ((regRdData & 8'hB0) != 0 && n < 5000) begin
      n++;
      @(negedge clk);
      #1;
    end
    checks++;
    if (n != exp) begin
      errors++;
      $display("FAIL %s busy cycles actual=%0d expected=%0d", req, n, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(3'd0, 8'h00, "R1");
    chk(3'd2, 8'h00, "R1");
    chk(3'd4, 8'h00, "R1");
    checks++;
    if (lineDriveLow !== 1'b0) begin
      errors++;
      $display("FAIL R1 lineDriveLow actual=%b expected=0", lineDriveLow);
    end

    // R2 R4 reset with a responding device, N=1
    slaveLow = 1'b1;
    wr(3'd0, 8'h80);
    chk(3'd0, 8'h80, "R2");
    repeat (2 * (RL + RW)) @(negedge clk);
    chk(3'd0, 8'h40, "R4 presence seen");
    slaveLow = 1'b0;
    measure(8'h80, RL + RW, "R2");
    chk(3'd0, 8'h00, "R4 no presence");

    // R5 R7 write-0 at N=3
    wr(3'd2, 8'd2);
    chk(3'd2, 8'd2, "R7");
    measure(8'h20, SL * 3, "R5 R7");
    chk(3'd0, expCtrl(), "R5");
    measure(8'h80, (RL + RW) * 3, "R7 reset scaled");

    // R6 read slots at N=1
    wr(3'd2, 8'd0);
    slaveLow = 1'b0;
    measure(8'h10, SL, "R6");
    chk(3'd0, 8'h08, "R6 read one");
    slaveLow = 1'b1;
    measure(8'h10, SL, "R6");
    chk(3'd0, 8'h00, "R6 read zero");
    slaveLow = 1'b0;

    // R9 priority
    wr(3'd0, 8'hB0);
    chk(3'd0, 8'h80, "R9 reset first");
    repeat (RL + RW + 2) @(negedge clk);
    wr(3'd0, 8'h30);
    chk(3'd0, expCtrl(), "R9");
    chk(3'd0, 8'h20, "R9 write-0 over read");
    repeat (SL + 2) @(negedge clk);

    // R10 writes while busy are ignored
    measure(8'h10, SL, "R6 setup");
    wr(3'd0, 8'h20);
    repeat (3) @(negedge clk);
    wr(3'd0, 8'h90);
    chk(3'd0, 8'h28, "R10 command held");
    repeat (SL) @(negedge clk);
    chk(3'd0, 8'h08, "R10 read bit kept");

    // R8 hold aborts and blocks
    slaveLow = 1'b1;
    wr(3'd0, 8'h80);
    repeat (RL + PR + 3) @(negedge clk);
    wr(3'd2, 8'd0);
    wr(3'd4, 8'h01);
    chk(3'd0, 8'h00, "R8 abort");
    chk(3'd4, 8'h01, "R8 hold readback");
    wr(3'd0, 8'h80);
    repeat (4) @(negedge clk);
    chk(3'd0, 8'h00, "R8 command ignored");
    wr(3'd2, 8'd1);
    wr(3'd4, 8'h00);
    chk(3'd2, 8'h01, "R8 divider kept");
    slaveLow = 1'b0;
    measure(8'h20, SL * 2, "R8 release");

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule